// File: doc/BRIEF.md
# Interleaved YUV Filter Sequencer

This block lets a single 5-tap filter serve three pixel component streams at once. The luma stream and the two chroma streams each arrive from their own input FIFO, and each stream keeps a private chain of four delay registers. A 2-bit phase counter picks which stream owns the filter in a given cycle. Two 3-way multiplexers steer the five tap values and the five 5-bit coefficient select codes of that stream to the filter ports. The filter arithmetic sits outside the block. It returns its result in the same cycle through `flt_res_i`.

Each output pixel takes three steps, always in the same order. The U result is produced and latched first, then the V result. The third step produces Y, and the block then presents Y together with the two latched chroma values as one 4:4:4 pixel for the colour converter. When a FIFO is empty, or the pixel consumer is not ready during the Y step, the sequencer stalls. During a stall the phase, the delay registers and the latched values all hold.

Top module: `yuv_interleave_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `phase_o` is 0, `pix_vld_o` is 0, and every delay register of every stream is zero, so tap slots 1 to 4 read zero until that stream accepts samples.
- R2: `phase_o` encodes the active stream as 0 for U, 1 for V and 2 for Y. It advances 0, 1, 2, 0 by one step for each accepted sample and never takes the value 3.
- R3: `src_pop_o` uses bit 0 for U, bit 1 for V and bit 2 for Y. Exactly the bit of the active stream is high when that stream's `src_vld_i` bit is high (and, at phase 2, `pix_rdy_i` is high). Otherwise no bit is high.
- R4: In a cycle with no pop, the phase, all delay registers and both chroma holding registers keep their values.
- R5: `tap_o` slot 0 (bits 7:0 by default) carries the active stream's current FIFO head. Slots 1 to 4 carry that stream's previous four accepted samples, newest first.
- R6: Accepting a sample on one stream leaves the delay registers of the other two streams unchanged.
- R7: `csel_o` equals the coefficient select word of the active stream (`csel_u_i`, `csel_v_i` or `csel_y_i`) in the same cycle.
- R8: On an accepted U step, `flt_res_i` is latched into the U holding register. On an accepted V step, it is latched into the V holding register. The holding registers are shown on `pix_u_o` and `pix_v_o`.
- R9: `pix_vld_o` is high exactly when the phase is 2 and the Y FIFO has data. At that time `pix_y_o` equals `flt_res_i`.
- R10: While `pix_vld_o` is high and `pix_rdy_i` is low, nothing is popped, the phase stays at 2, and the presented pixel is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_vld_i | input | 3 | FIFO not-empty flags: bit 0 U, bit 1 V, bit 2 Y |
| src_dat_i | input | 3*PIX_W | FIFO head samples, slot 0 U, slot 1 V, slot 2 Y |
| src_pop_o | output | 3 | FIFO pop strobes, same bit order |
| csel_u_i | input | NTAP*CSEL_W | Coefficient select codes for U |
| csel_v_i | input | NTAP*CSEL_W | Coefficient select codes for V |
| csel_y_i | input | NTAP*CSEL_W | Coefficient select codes for Y |
| tap_o | output | NTAP*PIX_W | Filter data inputs, slot 0 newest |
| csel_o | output | NTAP*CSEL_W | Coefficient select codes of the active stream |
| phase_o | output | 2 | Active stream: 0 U, 1 V, 2 Y |
| flt_res_i | input | PIX_W | Result from the external filter, same cycle |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_rdy_i | input | 1 | Output pixel accepted |
| pix_y_o | output | PIX_W | Luma of output pixel |
| pix_u_o | output | PIX_W | Latched U of output pixel |
| pix_v_o | output | PIX_W | Latched V of output pixel |

## Verification
The assertions assume three things. The FIFO flags and the ready input are ordinary synchronous inputs. The external filter answers combinationally within the same cycle. Reset is released away from the active edge. The stimulus drives the flags, ready and the coefficient words only at the falling edge. It models the filter as a combinational function of `tap_o` and `csel_o`, so the result always follows the presented taps. It releases reset at a falling edge. The sweep covers every combination of the three flags and ready over repeated passes, then a pseudo-random pattern and a full-throughput run. A second reset in the middle of the run checks that all delay chains clear.

// File: rtl/yuvseq_pkg.sv
package yuvseq_pkg;
  localparam int NSTREAM = 3;
  typedef enum logic [1:0] {
    PH_U = 2'd0,
    PH_V = 2'd1,
    PH_Y = 2'd2
  } phase_e;
endpackage

// File: rtl/yuvseq_tapline.sv
module yuvseq_tapline #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         shift_i,
  input  logic [PIX_W-1:0]             din_i,
  output logic [(DEPTH+1)*PIX_W-1:0]   taps_o
);
  logic [DEPTH-1:0][PIX_W-1:0] dl_q, dl_d;

  always_comb begin
    dl_d = dl_q;
    if (shift_i) begin
      dl_d[0] = din_i;
      for (int k = 1; k < DEPTH; k++) dl_d[k] = dl_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dl_q <= '0;
    else        dl_q <= dl_d;
  end

  assign taps_o[PIX_W-1:0] = din_i;
  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    assign taps_o[(g+1)*PIX_W +: PIX_W] = dl_q[g];
  end

  // private delay chain holds when its stream is not shifted
  p_line_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(taps_o[(DEPTH+1)*PIX_W-1:PIX_W]));
  // accepted sample becomes slot 1
  p_line_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> taps_o[2*PIX_W-1:PIX_W] == $past(din_i));
endmodule

// File: rtl/yuvseq_mux3.sv
module yuvseq_mux3 #(
  parameter int W = 8
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] in0_i,
  input  logic [W-1:0] in1_i,
  input  logic [W-1:0] in2_i,
  output logic [W-1:0] out_o
);
  always_comb begin
    case (sel_i)
      2'd0:    out_o = in0_i;
      2'd1:    out_o = in1_i;
      default: out_o = in2_i;
    endcase
  end
endmodule

// File: rtl/yuvseq_ctrl.sv
module yuvseq_ctrl
  import yuvseq_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       src_vld_i,
  input  logic             pix_rdy_i,
  input  logic [PIX_W-1:0] flt_res_i,
  output logic [1:0]       phase_o,
  output logic [2:0]       pop_o,
  output logic             pix_vld_o,
  output logic [PIX_W-1:0] pix_u_o,
  output logic [PIX_W-1:0] pix_v_o
);
  phase_e           ph_q, ph_d;
  logic [PIX_W-1:0] u_q, u_d, v_q, v_d;
  logic             step;

  always_comb begin
    step  = 1'b0;
    ph_d  = ph_q;
    pop_o = 3'b000;
    u_d   = u_q;
    v_d   = v_q;
    case (ph_q)
      PH_U: begin
        step = src_vld_i[0];
        if (step) begin
          pop_o = 3'b001;
          u_d   = flt_res_i;
          ph_d  = PH_V;
        end
      end
      PH_V: begin
        step = src_vld_i[1];
        if (step) begin
          pop_o = 3'b010;
          v_d   = flt_res_i;
          ph_d  = PH_Y;
        end
      end
      default: begin
        step = src_vld_i[2] & pix_rdy_i;
        if (step) begin
          pop_o = 3'b100;
          ph_d  = PH_U;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_U;
      u_q  <= '0;
      v_q  <= '0;
    end else begin
      ph_q <= ph_d;
      if (pop_o[0]) u_q <= u_d;
      if (pop_o[1]) v_q <= v_d;
    end
  end

  assign phase_o   = ph_q;
  assign pix_vld_o = (ph_q == PH_Y) & src_vld_i[2];
  assign pix_u_o   = u_q;
  assign pix_v_o   = v_q;

  p_phase_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o != 2'd3);
  p_pop_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_o));
  p_pop_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_o & ~src_vld_i) == 3'b000);
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o == 3'b000 |=> $stable(phase_o) && $stable(pix_u_o) && $stable(pix_v_o));
  p_u_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o[0] |=> phase_o == 2'd1 && pix_u_o == $past(flt_res_i));
  p_v_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o[1] |=> phase_o == 2'd2 && pix_v_o == $past(flt_res_i));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o[2] |=> phase_o == 2'd0);
  p_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_o && !pix_rdy_i |=> phase_o == 2'd2 && pop_o[0] == 1'b0);
  p_vld_on_y_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_o |-> phase_o == 2'd2);
endmodule

// File: rtl/yuv_interleave_seq.sv
module yuv_interleave_seq
  import yuvseq_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int NTAP   = 5,
  parameter int CSEL_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               src_vld_i,
  input  logic [3*PIX_W-1:0]       src_dat_i,
  output logic [2:0]               src_pop_o,
  input  logic [NTAP*CSEL_W-1:0]   csel_u_i,
  input  logic [NTAP*CSEL_W-1:0]   csel_v_i,
  input  logic [NTAP*CSEL_W-1:0]   csel_y_i,
  output logic [NTAP*PIX_W-1:0]    tap_o,
  output logic [NTAP*CSEL_W-1:0]   csel_o,
  output logic [1:0]               phase_o,
  input  logic [PIX_W-1:0]         flt_res_i,
  output logic                     pix_vld_o,
  input  logic                     pix_rdy_i,
  output logic [PIX_W-1:0]         pix_y_o,
  output logic [PIX_W-1:0]         pix_u_o,
  output logic [PIX_W-1:0]         pix_v_o
);
  localparam int DEPTH = NTAP - 1;
  localparam int TW    = NTAP * PIX_W;
  localparam int CW    = NTAP * CSEL_W;

  logic [NSTREAM-1:0][TW-1:0] taps_s;
  logic [1:0]                 ph;

  yuvseq_ctrl #(.PIX_W(PIX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_vld_i (src_vld_i),
    .pix_rdy_i (pix_rdy_i),
    .flt_res_i (flt_res_i),
    .phase_o   (ph),
    .pop_o     (src_pop_o),
    .pix_vld_o (pix_vld_o),
    .pix_u_o   (pix_u_o),
    .pix_v_o   (pix_v_o)
  );

  for (genvar s = 0; s < NSTREAM; s++) begin : g_line
    yuvseq_tapline #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (src_pop_o[s]),
      .din_i   (src_dat_i[s*PIX_W +: PIX_W]),
      .taps_o  (taps_s[s])
    );
  end

  yuvseq_mux3 #(.W(TW)) u_tap_mux (
    .sel_i (ph),
    .in0_i (taps_s[0]),
    .in1_i (taps_s[1]),
    .in2_i (taps_s[2]),
    .out_o (tap_o)
  );

  yuvseq_mux3 #(.W(CW)) u_csel_mux (
    .sel_i (ph),
    .in0_i (csel_u_i),
    .in1_i (csel_v_i),
    .in2_i (csel_y_i),
    .out_o (csel_o)
  );

  assign phase_o = ph;
  assign pix_y_o = flt_res_i;
endmodule

// File: tb/test_yuv_interleave_seq.sv
module test_yuv_interleave_seq;
  localparam int PIX_W = 8;
  localparam int NTAP = 5;
  localparam int CSEL_W = 5;
  localparam int TW = NTAP * PIX_W;
  localparam int CW = NTAP * CSEL_W;

  logic clk, rst_n;
  logic [2:0] src_vld, src_pop;
  logic [3*PIX_W-1:0] src_dat;
  logic [CW-1:0] csel_u, csel_v, csel_y, csel_o;
  logic [TW-1:0] tap_o;
  logic [1:0] phase;
  logic [PIX_W-1:0] flt, pix_y, pix_u, pix_v;
  logic pix_vld, pix_rdy;

  int n_tests = 0, n_fail = 0;
  int cnt [3];
  logic [7:0] hist [3][4];
  int m_ph, last_shift, cyc;
  bit m_stalled;
  logic [7:0] m_u, m_v;
  logic [15:0] lf;

  yuv_interleave_seq #(.PIX_W(PIX_W), .NTAP(NTAP), .CSEL_W(CSEL_W)) i_yuv_interleave_seq (
    .clk(clk), .rst_n(rst_n), .src_vld_i(src_vld), .src_dat_i(src_dat), .src_pop_o(src_pop),
    .csel_u_i(csel_u), .csel_v_i(csel_v), .csel_y_i(csel_y), .tap_o(tap_o), .csel_o(csel_o),
    .phase_o(phase), .flt_res_i(flt), .pix_vld_o(pix_vld), .pix_rdy_i(pix_rdy),
    .pix_y_o(pix_y), .pix_u_o(pix_u), .pix_v_o(pix_v)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] ffilt(input logic [TW-1:0] t, input logic [CW-1:0] c);
    logic [15:0] acc;
    acc = 16'd0;
    for (int k = 0; k < NTAP; k++)
      acc = acc + 16'(t[k*8 +: 8]) * 16'(2*k+1) + 16'(c[k*5 +: 5]);
    return acc[7:0] ^ acc[15:8];
  endfunction

  function automatic logic [7:0] gen(input int s, input int n);
    return 8'((s*85 + n*37 + 11) % 256);
  endfunction

  function automatic logic [CW-1:0] mkcsel(input int s, input int c);
    logic [CW-1:0] r;
    for (int k = 0; k < NTAP; k++) r[k*5 +: 5] = 5'((c*3 + s*7 + k*5) % 32);
    return r;
  endfunction

  assign flt = ffilt(tap_o, csel_o);  // stand-in external filter

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 3; s++) begin
      cnt[s] = 0;
      for (int k = 0; k < 4; k++) hist[s][k] = 8'd0;
    end
    m_ph = 0; last_shift = -1; m_stalled = 1'b0; m_u = 8'd0; m_v = 8'd0;
  endtask

  task automatic drive(input logic [2:0] v, input logic r);
    src_vld = v;
    pix_rdy = r;
    csel_u = mkcsel(0, cyc);
    csel_v = mkcsel(1, cyc);
    csel_y = mkcsel(2, cyc);
    for (int s = 0; s < 3; s++) src_dat[s*8 +: 8] = gen(s, cnt[s]);
  endtask

  function automatic logic [TW-1:0] exp_taps(input int s);
    return {hist[s][3], hist[s][2], hist[s][1], hist[s][0], gen(s, cnt[s])};
  endfunction

  task automatic step(input logic [2:0] v, input logic r);
    logic [TW-1:0] et;
    logic [CW-1:0] ec;
    logic [2:0] ep;
    logic [7:0] ef;
    bit adv;
    @(negedge clk);
    cyc++;
    drive(v, r);
    #1;
    et = exp_taps(m_ph);
    ec = (m_ph == 0) ? csel_u : (m_ph == 1) ? csel_v : csel_y;
    adv = v[m_ph] && (m_ph != 2 || r);
    ep = adv ? 3'(1 << m_ph) : 3'b000;
    chk(phase == 2'(m_ph), m_stalled ? "R4 phase held" : "R2 phase", 64'(phase), 64'(m_ph));
    chk(src_pop == ep, (m_ph == 2 && v[2] && !r) ? "R10 no pop" : "R3 pop", 64'(src_pop), 64'(ep));
    chk(tap_o == et, "R5 taps", 64'(tap_o), 64'(et));
    if (last_shift >= 0 && last_shift != m_ph)
      chk(tap_o[TW-1:8] == et[TW-1:8], "R6 private line", 64'(tap_o[TW-1:8]), 64'(et[TW-1:8]));
    chk(csel_o == ec, "R7 csel", 64'(csel_o), 64'(ec));
    chk(pix_vld == (m_ph == 2 && v[2]), "R9 valid", 64'(pix_vld), 64'(m_ph == 2 && v[2]));
    if (m_ph == 2 && v[2]) begin
      chk(pix_y == ffilt(et, ec), "R9 luma", 64'(pix_y), 64'(ffilt(et, ec)));
      chk(pix_u == m_u, "R8 u held", 64'(pix_u), 64'(m_u));
      chk(pix_v == m_v, "R8 v held", 64'(pix_v), 64'(m_v));
    end
    m_stalled = !adv;
    if (adv) begin
      ef = ffilt(et, ec);
      if (m_ph == 0) m_u = ef;
      if (m_ph == 1) m_v = ef;
      for (int k = 3; k > 0; k--) hist[m_ph][k] = hist[m_ph][k-1];
      hist[m_ph][0] = gen(m_ph, cnt[m_ph]);
      cnt[m_ph]++;
      last_shift = m_ph;
      m_ph = (m_ph + 1) % 3;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    drive(3'b000, 1'b0);
    #1;
    // R1: reset state observed at the ports
    chk(phase == 2'd0, "R1 phase", 64'(phase), 64'd0);
    chk(pix_vld == 1'b0, "R1 valid", 64'(pix_vld), 64'd0);
    chk(src_pop == 3'b000, "R1 pop", 64'(src_pop), 64'd0);
    chk(tap_o == exp_taps(0), "R1 taps zero", 64'(tap_o), 64'(exp_taps(0)));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc = 0;
    lf = 16'hACE1;
    rst_n = 1'b0;
    drive(3'b000, 1'b0);
    do_reset();
    for (int rep = 0; rep < 30; rep++)
      for (int c = 0; c < 16; c++) step(3'(c), c[3]);
    for (int i = 0; i < 2000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step({lf[2] | lf[5], lf[1] | lf[4], lf[0] | lf[3]}, lf[7] | lf[8]);
    end
    for (int i = 0; i < 300; i++) step(3'b111, 1'b1);
    do_reset();
    for (int i = 0; i < 3; i++) step(3'b111, 1'b1);
    for (int i = 0; i < 4; i++) step(3'b111, 1'b0);
    for (int rep = 0; rep < 10; rep++)
      for (int c = 15; c >= 0; c--) step(3'(c), c[0]);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule